// File: doc/BRIEF.md
# Indirect Interrupt Router Register Window

This block is the software-facing register front end of a 24-input interrupt router. Software reaches every register through two 32-bit locations: it first stores a register number in the select location at byte offset 0x00, and then reads or writes the chosen register through the data window at offset 0x10. The window exposes three global registers and 24 redirection entries. The global registers are an identifier, a computed version word and an arbitration word. Each redirection entry is two words: a configuration word and a destination word.

The delivery engine that sits beside this block drives two read-only status bits per input: delivery-in-progress and remote-acknowledge-pending. These bits show through the configuration words, and writes cannot change them. In return the block hands the engine the decoded fields of every entry in parallel. After each configuration write it raises a one-cycle pulse with the entry number, so that the engine re-evaluates that input. A global enable input blanks the whole interface: while it is low, reads return zero and writes are lost. Accesses use a single-cycle strobe, and read data is combinational in the cycle of the strobe.

Top module: `irw_top`

## Requirements
- R1: The select register sits at byte offset 0x00 and reads back the full 32-bit value last written. The data window sits at offset 0x10. Any other offset reads 0, and a write to it changes no register.
- R2: Window index 0 is the identifier. A read returns the 4-bit identifier in bits 27:24 with every other bit 0. A write stores bits 27:24 of the written data. The identifier is 0 after reset.
- R3: Window index 1 reads 0x11 ORed with (input count - 1) shifted left by 16, which is 0x00170011 for 24 inputs. Index 2 reads the identifier in bits 27:24. Writes to index 1 or 2 change nothing.
- R4: Indices 0x10 to 0x3F select entry (index - 0x10) >> 1. An even index selects that entry's configuration word and an odd index selects its destination word.
- R5: A destination write keeps bits 31:24 of the data and stores 0 in bits 23:0. The stored byte appears on that entry's slice of cfg_dest_o.
- R6: In a configuration word, bit 12 always reads the entry's dlv_busy_i bit and bit 14 always reads its rirr_i bit. Bits 31:17 read 0. A write stores only bits 16, 15, 13 and 11:0.
- R7: Entry n's fields drive the outputs: bits 7:0 drive cfg_vector_o[8n+7:8n], bits 10:8 drive cfg_dmode_o[3n+2:3n], bit 11 drives cfg_dstmode_o[n], bit 15 drives cfg_trig_o[n] (1 = level) and bit 16 drives cfg_mask_o[n].
- R8: After reset every configuration word holds only the mask bit (reads 0x00010000 when both status inputs are 0), and every destination word reads 0.
- R9: While glb_en is low, acc_rdata is 0 and writes to any offset change no register.
- R10: The cycle after an accepted configuration-word write, wr_pulse_o is 1 for one cycle and wr_entry_o holds the entry number. Destination writes and other writes produce no pulse.
- R11: A window index outside 0 to 2 and 0x10 to 0x3F reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable; low blanks all accesses |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (8) | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the strobe cycle |
| dlv_busy_i | input | N_IN (24) | Per-input delivery-in-progress status |
| rirr_i | input | N_IN (24) | Per-input remote-acknowledge-pending status |
| cfg_vector_o | output | N_IN*8 | Vector field of each entry |
| cfg_dmode_o | output | N_IN*3 | Delivery mode field of each entry |
| cfg_dstmode_o | output | N_IN | Destination mode bit of each entry |
| cfg_trig_o | output | N_IN | Trigger mode bit of each entry (1 = level) |
| cfg_mask_o | output | N_IN | Mask bit of each entry |
| cfg_dest_o | output | N_IN*8 | Destination byte of each entry |
| wr_pulse_o | output | 1 | One-cycle pulse after a configuration write |
| wr_entry_o | output | EW (5) | Entry number carried by wr_pulse_o |

## Verification
The hardest case to reach is a configuration write that arrives while the engine holds the status bits of the same entry high. Only then can the bench show that the status bits come from the engine and survive an all-ones write, while the writable neighbours around them change. The bench raises dlv_busy_i and rirr_i for one entry, writes all ones and then a sparse pattern to that entry through the window, and reads the word back between the writes. A second hard case is proving that an index inside the gap between the global registers and the table writes nothing. For this, the bench writes through such an index and then reads back the last entry and the identifier, the registers an off-by-one decode would most likely hit.

// File: rtl/irw_pkg.sv
package irw_pkg;

  localparam int unsigned FIRST_ENTRY_IDX = 16;
  localparam logic [31:0] CFG_WR_MASK     = 32'h0001_AFFF;
  localparam logic [31:0] CFG_RESET       = 32'h0001_0000;
  localparam int unsigned BUSY_BIT        = 12;
  localparam int unsigned RIRR_BIT        = 14;

  // Version word: low byte 0x11, highest entry number in bits 23:16.
  function automatic logic [31:0] version_word(int unsigned n_in);
    logic [31:0] top_entry;
    top_entry = 32'(n_in - 1);
    return 32'h0000_0011 | (top_entry << 16);
  endfunction

  function automatic logic [31:0] id_word(logic [3:0] id);
    return {4'b0000, id, 24'h00_0000};
  endfunction

  function automatic logic index_in_table(logic [31:0] sel, int unsigned n_in);
    return (sel >= 32'(FIRST_ENTRY_IDX)) && (sel < 32'(FIRST_ENTRY_IDX + 2 * n_in));
  endfunction

  // Visible configuration word: stored writable bits plus engine status.
  function automatic logic [31:0] cfg_view(logic [31:0] stored, logic busy, logic rirr);
    logic [31:0] v;
    v = stored & CFG_WR_MASK;
    v[BUSY_BIT] = busy;
    v[RIRR_BIT] = rirr;
    return v;
  endfunction

endpackage

// File: rtl/irw_decode.sv
module irw_decode
  import irw_pkg::*;
#(
  parameter int unsigned N_IN   = 24,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned EW     = $clog2(N_IN)
) (
  input  logic              glb_en,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       sel_q,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              win_rd,
  output logic              id_wr,
  output logic              ent_hit,
  output logic              ent_odd,
  output logic [EW-1:0]     ent_num,
  output logic              cfg_wr,
  output logic              dst_wr
);
  localparam logic [ADDR_W-1:0] IDX_OFF = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] WIN_OFF = ADDR_W'(16);

  logic        go;
  logic        at_idx;
  logic        at_win;
  logic        win_wr;
  logic [31:0] rel;

  assign go     = acc_valid & glb_en;
  assign at_idx = (acc_addr == IDX_OFF);
  assign at_win = (acc_addr == WIN_OFF);

  assign idx_wr = go & acc_write & at_idx;
  assign idx_rd = go & ~acc_write & at_idx;
  assign win_wr = go & acc_write & at_win;
  assign win_rd = go & ~acc_write & at_win;

  assign rel     = sel_q - 32'(FIRST_ENTRY_IDX);
  assign ent_hit = index_in_table(sel_q, N_IN);
  assign ent_odd = sel_q[0];
  assign ent_num = rel[EW:1];

  assign id_wr  = win_wr & (sel_q == 32'd0);
  assign cfg_wr = win_wr & ent_hit & ~ent_odd;
  assign dst_wr = win_wr & ent_hit & ent_odd;
endmodule

// File: rtl/irw_entry.sv
module irw_entry
  import irw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cfg,
  input  logic        wr_dst,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        rirr,
  output logic [31:0] cfg_word,
  output logic [31:0] dst_word
);
  logic [31:0] cfg_q;
  logic [7:0]  dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      dst_q <= 8'h00;
    end else begin
      if (wr_cfg) cfg_q <= wdata & CFG_WR_MASK;
      if (wr_dst) dst_q <= wdata[31:24];
    end
  end

  assign cfg_word = cfg_view(cfg_q, busy, rirr);
  assign dst_word = {dst_q, 24'h00_0000};
endmodule

// File: rtl/irw_read_mux.sv
module irw_read_mux
  import irw_pkg::*;
#(
  parameter int unsigned N_IN = 24,
  parameter int unsigned EW   = $clog2(N_IN)
) (
  input  logic        idx_rd,
  input  logic        win_rd,
  input  logic [31:0] sel_q,
  input  logic [3:0]  id_q,
  input  logic        ent_hit,
  input  logic        ent_odd,
  input  logic [EW-1:0] ent_num,
  input  logic [31:0] cfg_words [N_IN],
  input  logic [31:0] dst_words [N_IN],
  output logic [31:0] rdata
);
  logic [31:0] win_val;

  always_comb begin
    win_val = 32'h0;
    if (sel_q == 32'd0 || sel_q == 32'd2) begin
      win_val = id_word(id_q);
    end else if (sel_q == 32'd1) begin
      win_val = version_word(N_IN);
    end else if (ent_hit) begin
      for (int i = 0; i < N_IN; i++) begin
        if (ent_num == EW'(i)) win_val = ent_odd ? dst_words[i] : cfg_words[i];
      end
    end
  end

  always_comb begin
    rdata = 32'h0;
    if (idx_rd)      rdata = sel_q;
    else if (win_rd) rdata = win_val;
  end
endmodule

// File: rtl/irw_top.sv
module irw_top
  import irw_pkg::*;
#(
  parameter int unsigned N_IN   = 24,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned EW     = $clog2(N_IN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                glb_en,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [31:0]         acc_wdata,
  output logic [31:0]         acc_rdata,
  input  logic [N_IN-1:0]     dlv_busy_i,
  input  logic [N_IN-1:0]     rirr_i,
  output logic [N_IN*8-1:0]   cfg_vector_o,
  output logic [N_IN*3-1:0]   cfg_dmode_o,
  output logic [N_IN-1:0]     cfg_dstmode_o,
  output logic [N_IN-1:0]     cfg_trig_o,
  output logic [N_IN-1:0]     cfg_mask_o,
  output logic [N_IN*8-1:0]   cfg_dest_o,
  output logic                wr_pulse_o,
  output logic [EW-1:0]       wr_entry_o
);
  logic [31:0]   sel_q;
  logic [3:0]    id_q;
  logic          idx_wr, idx_rd, win_rd, id_wr;
  logic          ent_hit, ent_odd;
  logic [EW-1:0] ent_num;
  logic          cfg_wr_evt, dst_wr_evt;
  logic [31:0]   cfg_words [N_IN];
  logic [31:0]   dst_words [N_IN];

  irw_decode #(.N_IN(N_IN), .ADDR_W(ADDR_W), .EW(EW)) u_dec (
    .glb_en(glb_en), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .sel_q(sel_q),
    .idx_wr(idx_wr), .idx_rd(idx_rd), .win_rd(win_rd), .id_wr(id_wr),
    .ent_hit(ent_hit), .ent_odd(ent_odd), .ent_num(ent_num),
    .cfg_wr(cfg_wr_evt), .dst_wr(dst_wr_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 32'h0;
      id_q       <= 4'h0;
      wr_pulse_o <= 1'b0;
      wr_entry_o <= '0;
    end else begin
      if (idx_wr) sel_q <= acc_wdata;
      if (id_wr)  id_q  <= acc_wdata[27:24];
      wr_pulse_o <= cfg_wr_evt;
      if (cfg_wr_evt) wr_entry_o <= ent_num;
    end
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_ent
    logic sel_me;
    assign sel_me = (ent_num == EW'(g));
    irw_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_cfg(cfg_wr_evt & sel_me), .wr_dst(dst_wr_evt & sel_me),
      .wdata(acc_wdata), .busy(dlv_busy_i[g]), .rirr(rirr_i[g]),
      .cfg_word(cfg_words[g]), .dst_word(dst_words[g])
    );
    assign cfg_vector_o[g*8 +: 8] = cfg_words[g][7:0];
    assign cfg_dmode_o[g*3 +: 3]  = cfg_words[g][10:8];
    assign cfg_dstmode_o[g]       = cfg_words[g][11];
    assign cfg_trig_o[g]          = cfg_words[g][15];
    assign cfg_mask_o[g]          = cfg_words[g][16];
    assign cfg_dest_o[g*8 +: 8]   = dst_words[g][31:24];
  end

  irw_read_mux #(.N_IN(N_IN), .EW(EW)) u_rd (
    .idx_rd(idx_rd), .win_rd(win_rd), .sel_q(sel_q), .id_q(id_q),
    .ent_hit(ent_hit), .ent_odd(ent_odd), .ent_num(ent_num),
    .cfg_words(cfg_words), .dst_words(dst_words), .rdata(acc_rdata)
  );
endmodule

// File: rtl/irw_chk.sv
module irw_chk #(
  parameter int unsigned N_IN = 24,
  parameter int unsigned EW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            glb_en,
  input logic [31:0]     acc_rdata,
  input logic            win_rd,
  input logic [31:0]     sel_q,
  input logic            ent_hit,
  input logic            ent_odd,
  input logic [EW-1:0]   ent_num,
  input logic            cfg_wr_evt,
  input logic            wr_pulse_o,
  input logic [EW-1:0]   wr_entry_o,
  input logic [N_IN-1:0] cfg_mask_o
);
  logic [31:0] exp_ver;
  assign exp_ver = 32'h11 | (32'(N_IN - 1) << 16);

  // R9
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> acc_rdata == 32'h0);
  // R10
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> $past(cfg_wr_evt));
  // R10
  pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_evt |=> wr_pulse_o && wr_entry_o == $past(ent_num));
  // R5
  dst_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && ent_hit && ent_odd) |-> acc_rdata[23:0] == 24'h0);
  // R3
  version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && sel_q == 32'd1) |-> acc_rdata == exp_ver);
  // R11
  gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && sel_q > 32'd2 && !ent_hit) |-> acc_rdata == 32'h0);
  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_evt |=> $stable(cfg_mask_o));
endmodule

bind irw_top irw_chk #(.N_IN(N_IN), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .acc_rdata(acc_rdata),
  .win_rd(win_rd), .sel_q(sel_q), .ent_hit(ent_hit), .ent_odd(ent_odd),
  .ent_num(ent_num), .cfg_wr_evt(cfg_wr_evt), .wr_pulse_o(wr_pulse_o),
  .wr_entry_o(wr_entry_o), .cfg_mask_o(cfg_mask_o)
);

// File: tb/sim_irw_top.sv
`timescale 1ns/1ps
module sim_irw_top;
  localparam int N = 24;
  localparam int EW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            glb_en = 1'b1;
  logic            acc_valid = 1'b0;
  logic            acc_write = 1'b0;
  logic [7:0]      acc_addr = 8'h0;
  logic [31:0]     acc_wdata = 32'h0;
  logic [31:0]     acc_rdata;
  logic [N-1:0]    dlv_busy_i = '0;
  logic [N-1:0]    rirr_i = '0;
  logic [N*8-1:0]  cfg_vector_o;
  logic [N*3-1:0]  cfg_dmode_o;
  logic [N-1:0]    cfg_dstmode_o, cfg_trig_o, cfg_mask_o;
  logic [N*8-1:0]  cfg_dest_o;
  logic            wr_pulse_o;
  logic [EW-1:0]   wr_entry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irw_top u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .dlv_busy_i(dlv_busy_i), .rirr_i(rirr_i),
    .cfg_vector_o(cfg_vector_o), .cfg_dmode_o(cfg_dmode_o),
    .cfg_dstmode_o(cfg_dstmode_o), .cfg_trig_o(cfg_trig_o),
    .cfg_mask_o(cfg_mask_o), .cfg_dest_o(cfg_dest_o),
    .wr_pulse_o(wr_pulse_o), .wr_entry_o(wr_entry_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    #1 d = acc_rdata;
    acc_valid = 1'b0;
  endtask

  task automatic rd_idx(logic [31:0] idx, output logic [31:0] d);
    wr(8'h00, idx);
    rd(8'h10, d);
  endtask

  function automatic logic [31:0] cfg_idx(int e); return 32'(16 + 2 * e); endfunction
  function automatic logic [31:0] dst_idx(int e); return 32'(17 + 2 * e); endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd_idx(32'd0, v);        check("R2 id after reset", v, 32'h0);
    rd_idx(cfg_idx(0), v);   check("R8 cfg0 reset", v, 32'h0001_0000);
    rd_idx(cfg_idx(23), v);  check("R8 cfg23 reset", v, 32'h0001_0000);
    rd_idx(dst_idx(9), v);   check("R8 dst9 reset", v, 32'h0);
    check("R8 mask outputs", 32'(cfg_mask_o), 32'h00FF_FFFF);
  endtask

  task automatic t_offsets();
    logic [31:0] v;
    wr(8'h00, 32'hDEAD_BEEF);
    rd(8'h00, v);            check("R1 select readback", v, 32'hDEAD_BEEF);
    rd(8'h04, v);            check("R1 other offset reads 0", v, 32'h0);
    wr(8'h04, 32'h0000_0000);
    rd(8'h00, v);            check("R1 other offset write ignored", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_id_ver();
    logic [31:0] v;
    wr(8'h00, 32'd0); wr(8'h10, 32'hFA55_5555);
    rd(8'h10, v);            check("R2 id store", v, 32'h0A00_0000);
    rd_idx(32'd1, v);        check("R3 version", v, 32'h0017_0011);
    rd_idx(32'd2, v);        check("R3 arbitration", v, 32'h0A00_0000);
    wr(8'h10, 32'h0500_0000);
    rd(8'h10, v);            check("R3 write idx2 ignored", v, 32'h0A00_0000);
    wr(8'h00, 32'd1); wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v);            check("R3 write idx1 ignored", v, 32'h0017_0011);
  endtask

  task automatic t_entries();
    logic [31:0] v;
    dlv_busy_i[5] = 1'b1; rirr_i[5] = 1'b1;
    wr(8'h00, cfg_idx(5)); wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v);            check("R6 ro bits kept, status shown", v, 32'h0001_FFFF);
    check("R7 vector", 32'(cfg_vector_o[5*8 +: 8]), 32'hFF);
    check("R7 trig/mask/dstmode", {29'h0, cfg_trig_o[5], cfg_mask_o[5], cfg_dstmode_o[5]}, 32'h7);
    wr(8'h10, 32'h0000_0A31);
    rd(8'h10, v);            check("R6 sparse write with status", v, 32'h0000_5A31);
    dlv_busy_i[5] = 1'b0; rirr_i[5] = 1'b0;
    rd(8'h10, v);            check("R6 status cleared", v, 32'h0000_0A31);
    check("R7 dmode", 32'(cfg_dmode_o[5*3 +: 3]), 32'h2);
    check("R7 mask off", 32'(cfg_mask_o[5]), 32'h0);
    rd_idx(cfg_idx(4), v);   check("R4 neighbour cfg untouched", v, 32'h0001_0000);
    wr(8'h00, dst_idx(23)); wr(8'h10, 32'h1234_5678);
    rd(8'h10, v);            check("R5 dest low bits zero", v, 32'h1200_0000);
    check("R5 dest output", 32'(cfg_dest_o[23*8 +: 8]), 32'h12);
    rd_idx(cfg_idx(23), v);  check("R4 odd index hits dest only", v, 32'h0001_0000);
  endtask

  task automatic t_pulse();
    wr(8'h00, cfg_idx(17));
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 8'h10; acc_wdata = 32'h0000_0040;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check("R10 pulse high", 32'(wr_pulse_o), 32'h1);
    check("R10 entry number", 32'(wr_entry_o), 32'd17);
    @(negedge clk);
    check("R10 pulse one cycle", 32'(wr_pulse_o), 32'h0);
    wr(8'h00, dst_idx(17));
    check("R10 no pulse on select write", 32'(wr_pulse_o), 32'h0);
    wr(8'h10, 32'hAB00_0000);
    check("R10 no pulse on dest write", 32'(wr_pulse_o), 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(8'h00, 32'd0);
    glb_en = 1'b0;
    wr(8'h10, 32'h0300_0000);
    wr(8'h00, 32'd1);
    rd(8'h10, v);            check("R9 read blanked", v, 32'h0);
    glb_en = 1'b1;
    rd(8'h10, v);            check("R9 id write dropped", v, 32'h0A00_0000);
    rd(8'h00, v);            check("R9 select write dropped", v, 32'h0);
  endtask

  task automatic t_gaps();
    logic [31:0] v;
    rd_idx(32'd3, v);        check("R11 idx3 reads 0", v, 32'h0);
    rd_idx(32'h40, v);       check("R11 idx 0x40 reads 0", v, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_idx(dst_idx(23), v);  check("R11 write 0x40 ignored", v, 32'h1200_0000);
    wr(8'h00, 32'h0F); wr(8'h10, 32'hFFFF_FFFF);
    rd_idx(32'd0, v);        check("R11 write 0x0F ignored", v, 32'h0A00_0000);
    rd_idx(cfg_idx(0), v);   check("R11 cfg0 untouched", v, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_offsets();
    t_id_ver();
    t_entries();
    t_pulse();
    t_gate();
    t_gaps();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule